// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is an I2C slave that sits in front of a 512-byte byte-wide memory. The memory is split into two 256-byte blocks, and each block holds sixteen pages of sixteen bytes. SCL and SDA come in asynchronously. They pass through a short synchronizer clocked by a fast system clock, and the block then finds clock edges and START and STOP conditions on the sampled levels. SDA leaves the block only as a pull-low enable, so the line is open-drain and the block never drives it high.

A transaction starts with a slave-address byte. From most significant bit down, it holds a fixed 4-bit device code, two bits that must equal the hardware address pins, the block-select bit, and the read/write bit. A write carries a one-byte word address and then data bytes. These may form a single byte write or a page write that wraps inside the addressed page. Reads come in three kinds. A current-address read continues from the internal address counter. A random read first does a dummy write of the word address and then sends a repeated START. A sequential read keeps going while the master acknowledges. A write-protect input blocks programming of the upper block but lets every address byte through.

The controller is one state machine. ST_IDLE waits for a START. ST_DEV receives the slave address and goes to ST_DEV_ACK on a match, or to ST_IDLE on a mismatch. ST_DEV_ACK goes to ST_RDATA for a read or to ST_WORD for a write. ST_WORD goes to ST_WORD_ACK, which goes to ST_WDATA. ST_WDATA goes to ST_WDATA_ACK when the byte is stored, or to ST_IDLE when the write is refused. ST_WDATA_ACK returns to ST_WDATA. ST_RDATA goes to ST_RDATA_ACK after eight bits. ST_RDATA_ACK goes back to ST_RDATA on a master ACK, or to ST_IDLE on a NACK. From any state, a STOP leads to ST_IDLE and a START leads to ST_DEV.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset, and in idle, the block does not pull SDA. Bytes clocked in before any START get no acknowledge.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes sent after a STOP without a new START get no acknowledge.
- R3: A slave-address byte is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:2 equal `dev_pins_i[1:0]`. Bit 1 selects the block (memory address bit 8). Bit 0 set to 1 means read.
- R4: The block pulls SDA low during the ninth SCL pulse of every byte it accepts. This covers the slave address, the word address and the data bytes.
- R5: A byte write stores its data byte at memory address {block bit, word address}.
- R6: During a write, the low 4 address bits advance after each byte and wrap within the 16-byte page. The upper address bits do not change.
- R7: With `wp_i` high, a data byte aimed at the upper block (address bit 8 = 1) is not acknowledged and not stored. The slave-address and word-address bytes are still acknowledged.
- R8: With `wp_i` high, writes to the lower block still succeed. With `wp_i` low, writes to the upper block succeed. Reads are allowed in every case.
- R9: A current-address read returns the byte that follows the last byte accessed. Bit 8 of the address is taken from the block bit of the read command.
- R10: A random read returns the byte at the word address given by the dummy write, once the repeated START and read command have been sent.
- R11: A sequential read increments the address across all 512 bytes and rolls over from 511 to 0.
- R12: After the master NACKs a read byte, the block releases SDA and stays idle until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| dev_pins_i | input | 2 | Hardware address pins compared with slave-address bits 3:2 |
| wp_i | input | 1 | Write protect for the upper block |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench builds the block with its default parameters: 16-byte pages, 256-byte blocks and two synchronizer stages. It ties the address pins to 2'b01. At this size every address is in reach. The bench programs the whole array with thirty-two page writes, reads it back in one sequential pass that runs past address 511 into the rollover, and checks every byte against a pattern it computes arithmetically. It also sweeps all 64 combinations of device code and pin bits to check address matching. Page wrap, write protect on each block, the current-address and random read forms, and the behaviour after STOP and NACK are each exercised separately.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } ee_state_t;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] scl_sh, sda_sh;
    logic         scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[W-2:0], scl_i};
            sda_sh <= {sda_sh[W-2:0], sda_i};
        end
    end

    assign scl_lvl  = scl_sh[W-2];
    assign sda_lvl  = sda_sh[W-2];
    assign scl_prev = scl_sh[W-1];
    assign sda_prev = sda_sh[W-1];

    assign scl_rise  = scl_lvl && !scl_prev;
    assign scl_fall  = !scl_lvl && scl_prev;
    assign start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
    assign stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
    import ee_i2c_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int BLOCK_BYTES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_pins_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int WORD_W = $clog2(BLOCK_BYTES);
    localparam int ADDR_W = WORD_W + 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    ee_state_t         state, nxt;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] addr;
    logic              rw_q, mack_q;
    logic [7:0]        rdata;

    logic byte_done, dev_hit, wr_blocked, mem_we, rx_state;

    assign byte_done  = scl_fall && (bit_cnt == 4'd8);
    assign dev_hit    = (shreg[7:4] == DEV_CODE) && (shreg[3:2] == dev_pins_i);
    assign wr_blocked = wp_i && addr[ADDR_W-1];
    assign mem_we     = (state == ST_WDATA) && byte_done && !wr_blocked;
    assign rx_state   = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);

    ee_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk(clk), .we(mem_we), .waddr(addr), .wdata(shreg),
        .raddr(addr), .rdata(rdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) nxt = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:      if (byte_done) nxt = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = wr_blocked ? ST_IDLE : ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = mack_q ? ST_RDATA : ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            if (start_det || nxt != state) bit_cnt <= '0;
            else if (rx_state && scl_rise) bit_cnt <= bit_cnt + 4'd1;
            else if (state == ST_RDATA && scl_fall) bit_cnt <= bit_cnt + 4'd1;

            if (rx_state && scl_rise) shreg <= {shreg[6:0], sda_lvl};

            if (state == ST_DEV && byte_done && dev_hit) begin
                rw_q           <= shreg[0];
                addr[ADDR_W-1] <= shreg[1];
            end
            if (state == ST_WORD && byte_done) addr[WORD_W-1:0] <= shreg[WORD_W-1:0];
            if (mem_we) addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;

            if (nxt == ST_RDATA && state != ST_RDATA) begin
                shreg <= rdata;
                addr  <= addr + 1'b1;
            end else if (state == ST_RDATA && scl_fall) begin
                shreg <= {shreg[6:0], 1'b1};
            end
            if (state == ST_RDATA_ACK && scl_rise) mack_q <= !sda_lvl;
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                              sda_pull_o = !shreg[7];
            default:                               sda_pull_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ee_i2c_checker.sv
module ee_i2c_checker
    import ee_i2c_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input ee_state_t state,
    input logic      start_det,
    input logic      stop_det,
    input logic      scl_lvl,
    input logic      mem_we,
    input logic      wp_i,
    input logic      waddr_top,
    input logic      sda_pull_o
);
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE); // R2
    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> state == ST_DEV); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_pull_o); // R12
    AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_i && waddr_top)); // R7
    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl); // R4
endmodule

bind ee_i2c_slave ee_i2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .start_det(start_det),
    .stop_det(stop_det), .scl_lvl(scl_lvl), .mem_we(mem_we), .wp_i(wp_i),
    .waddr_top(addr[ADDR_W-1]), .sda_pull_o(sda_pull_o)
);

// File: tb/ee_i2c_slave_bench.sv
module ee_i2c_slave_bench;
    localparam int         Q    = 3;
    localparam logic [1:0] PINS = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_pull;
    wire  sda_bus = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    ee_i2c_slave u_ee_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .dev_pins_i(PINS), .wp_i(wp), .sda_pull_o(sda_pull)
    );

    int   errors = 0, checks = 0;
    bit   done = 0;
    logic [7:0] mdl [512];

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 0; wq(1); sda_m = 1; wq(1); scl_m = 1; wq(1); sda_m = 0; wq(1); scl_m = 0; wq(1);
    endtask

    task automatic bus_stop();
        scl_m = 0; wq(1); sda_m = 0; wq(1); scl_m = 1; wq(1); sda_m = 1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 0; wq(1); sda_m = b[i]; wq(1); scl_m = 1; wq(2);
        end
        scl_m = 0; wq(1); sda_m = 1; wq(1); scl_m = 1; wq(1);
        ack = !sda_bus;
        wq(1); scl_m = 0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        sda_m = 1;
        for (int i = 0; i < 8; i++) begin
            scl_m = 0; wq(2); scl_m = 1; wq(1); b = {b[6:0], sda_bus}; wq(1);
        end
        scl_m = 0; wq(1); sda_m = !mack; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1); sda_m = 1;
    endtask

    function automatic logic [7:0] devb(bit blk, bit rd);
        return {4'b1010, PINS, blk, rd};
    endfunction

    // dummy write of address, repeated START, read n bytes and compare
    task automatic rd_seq(int a, int n, string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(devb(a[8], 0), ack); chk(ack, {tag, " dev ack R4"}, ack, 1);
        send_byte(8'(a), ack);         chk(ack, {tag, " word ack R4"}, ack, 1);
        bus_start();
        send_byte(devb(a[8], 1), ack); chk(ack, {tag, " read cmd ack R4"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(b === mdl[(a + i) % 512], tag, b, mdl[(a + i) % 512]);
        end
        wq(2);
        chk(!sda_pull, "R12 release after NACK", sda_pull, 0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1;
        wq(2);
        chk(!sda_pull, "R1 reset no pull", sda_pull, 0);

        // byte without START
        send_byte(devb(0, 0), ack);
        chk(!ack, "R1 no START no ack", ack, 0);
        bus_stop();

        // address match sweep
        for (int t = 0; t < 16; t++)
            for (int p = 0; p < 4; p++) begin
                bus_start();
                send_byte({4'(t), 2'(p), 2'b00}, ack);
                chk(ack == (t == 10 && p == int'(PINS)), "R3 address match", ack, (t == 10 && p == int'(PINS)));
                bus_stop();
            end

        // fill array with page writes
        for (int pg = 0; pg < 32; pg++) begin
            bus_start();
            send_byte(devb(pg[4], 0), ack); chk(ack, "R4 fill dev ack", ack, 1);
            send_byte(8'(pg * 16), ack);    chk(ack, "R4 fill word ack", ack, 1);
            for (int k = 0; k < 16; k++) begin
                send_byte(pat(pg * 16 + k), ack);
                chk(ack, "R5 fill data ack", ack, 1);
                mdl[pg * 16 + k] = pat(pg * 16 + k);
            end
            bus_stop();
        end

        // full sequential pass with rollover
        rd_seq(0, 513, "R11 sequential");

        // byte write + random read + current-address read
        bus_start();
        send_byte(devb(1, 0), ack); send_byte(8'hA5, ack);
        send_byte(8'h3C, ack); chk(ack, "R5 byte write ack", ack, 1);
        bus_stop();
        mdl[9'h1A5] = 8'h3C;
        rd_seq(9'h1A5, 1, "R10 random read");
        bus_start();
        send_byte(devb(1, 1), ack); chk(ack, "R9 cur read ack", ack, 1);
        recv_byte(b, 0);
        chk(b === mdl[9'h1A6], "R9 current address read", b, mdl[9'h1A6]);
        bus_stop();

        // page wrap: 18 bytes starting at offset 14
        bus_start();
        send_byte(devb(0, 0), ack); send_byte(8'hFE, ack);
        for (int i = 0; i < 18; i++) begin
            send_byte(8'(8'hC0 + i), ack);
            chk(ack, "R6 wrap data ack", ack, 1);
            mdl[8'hF0 + ((14 + i) & 15)] = 8'(8'hC0 + i);
        end
        bus_stop();
        rd_seq(9'h0F0, 17, "R6 page wrap");

        // write protect
        wp = 1;
        bus_start();
        send_byte(devb(1, 0), ack); chk(ack, "R7 wp dev ack", ack, 1);
        send_byte(8'h10, ack);      chk(ack, "R7 wp word ack", ack, 1);
        send_byte(8'h99, ack);      chk(!ack, "R7 wp data nack", ack, 0);
        bus_stop();
        rd_seq(9'h110, 1, "R7 protected byte unchanged");
        bus_start();
        send_byte(devb(0, 0), ack); send_byte(8'h20, ack);
        send_byte(8'h77, ack); chk(ack, "R8 wp lower write ack", ack, 1);
        bus_stop();
        mdl[9'h020] = 8'h77;
        rd_seq(9'h020, 1, "R8 lower write with wp");
        wp = 0;
        bus_start();
        send_byte(devb(1, 0), ack); send_byte(8'h10, ack);
        send_byte(8'h55, ack); chk(ack, "R8 upper write ack", ack, 1);
        bus_stop();
        mdl[9'h110] = 8'h55;
        rd_seq(9'h110, 1, "R8 upper write without wp");

        // traffic after STOP
        bus_start();
        send_byte(devb(0, 0), ack);
        bus_stop();
        send_byte(devb(0, 0), ack);
        chk(!ack, "R2 ignored after STOP", ack, 0);
        bus_stop();

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule